// File: doc/BRIEF.md
# Signed Add/Subtract Sequencer

This block is a small sequential arithmetic unit for a calculator-style front end. The user enters a first operand as a 7-bit magnitude with a sign, then an operator (add or subtract), then a second signed operand, and finally an equals strobe. Each operand is turned into an 8-bit two's-complement word as it is stored. A controller then steps one shared ripple adder through the operation. For subtraction, the adder takes the ones'-complement of the second operand with a carry-in of 1.

When the sum is ready, the controller tests its sign bit. A negative sum is fed back through the same adder to form its two's complement, and a minus flag is raised. The result therefore comes out as a magnitude with a sign flag, ready for a display path. An overflow flag records when the signed sum did not fit in the word. A one-cycle completion pulse marks the end of each operation.

Top module: `addsub_calc_seq`

## Requirements
- R1: A positive entry is stored as its 7-bit magnitude with bit 7 cleared. A negative entry is stored as the 8-bit two's complement of that magnitude (entryNeg=1 means negative).
- R2: Input is accepted only in this order: first operand (entryValid), operator (opValid, with opSub=1 for subtract and 0 for add), second operand (entryValid), then eqStrobe. A strobe that arrives outside its slot is ignored. This includes a further operand entry or operator while the unit waits for equals.
- R3: For addition, the internal result is the sum of the two stored words modulo 256. Any carry out of bit 7 is dropped.
- R4: For subtraction, the second stored word is ones'-complemented and added to the first with a carry-in of 1, giving first minus second modulo 256.
- R5: If bit 7 of the result is 0, resultMag equals the result and resultNeg is 0. If bit 7 is 1, resultMag becomes the two's complement of the result and resultNeg is 1. For example, 9−4 gives magnitude 5 positive, and 4−9 (internally 1111_1011) gives magnitude 5 negative.
- R6: ovfFlag is set when the signed result lies outside −128..127 and is cleared otherwise. It is updated only when an operation executes and holds its value until the next one.
- R7: donePulse is high for exactly one cycle. It is sampled in the 2nd clock cycle after the equals edge when the result is non-negative, and in the 3rd cycle when it is negative. busy is high from execution through the completion cycle and low the cycle after.
- R8: An operand entry or operator that arrives while busy is high is ignored. It changes neither the running result nor the completion timing.
- R9: After reset, resultMag, resultNeg, ovfFlag, busy and donePulse are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| entryValid | input | 1 | Operand entry strobe |
| entryNeg | input | 1 | Sign of the entered operand, 1 = negative |
| entryMag | input | W-1 | Magnitude of the entered operand |
| opValid | input | 1 | Operator entry strobe |
| opSub | input | 1 | Operator code, 1 = subtract, 0 = add |
| eqStrobe | input | 1 | Equals strobe that starts execution |
| resultMag | output | W | Result magnitude for display |
| resultNeg | output | 1 | Result is negative |
| ovfFlag | output | 1 | Signed overflow of the last operation |
| busy | output | 1 | Operation in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps a grid of magnitudes that covers 0, 127 and values in between, under every combination of operand signs and both operators, and computes the expected signed result with integer arithmetic. It targets the following mistakes:
- A missing carry-in on subtraction would leave every difference off by one.
- A skipped fix-up pass would show raw two's-complement words as large magnitudes.
- Wrong overflow logic would mis-flag sums such as 100+100 or −127−127.
- A bad sign-test branch would move donePulse to the wrong cycle.

Stray operand and operator strobes are injected while the unit waits for equals and while it is busy. A design that latched any of them would produce a wrong magnitude or sign, or would shift the completion timing.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD_A, S_LOAD_OP, S_LOAD_B, S_EXEC, S_SIGN_TEST, S_FIXUP, S_DONE
  } seqState_t;

  typedef struct packed {
    logic loadA;
    logic loadOp;
    logic loadB;
    logic exec;
    logic fix;
  } ctrlStb_t;
endpackage

// File: rtl/calc_adder.sv
module calc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/calc_control.sv
module calc_control
  import calc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     entryValid,
  input  logic     opValid,
  input  logic     eqStrobe,
  input  logic     resMsb,
  output ctrlStb_t stb,
  output logic     busy,
  output logic     donePulse
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:      if (entryValid) stateNext = S_LOAD_A;
      S_LOAD_A:    if (opValid)    stateNext = S_LOAD_OP;
      S_LOAD_OP:   if (entryValid) stateNext = S_LOAD_B;
      S_LOAD_B:    if (eqStrobe)   stateNext = S_EXEC;
      S_EXEC:      stateNext = S_SIGN_TEST;
      S_SIGN_TEST: stateNext = resMsb ? S_FIXUP : S_DONE;
      S_FIXUP:     stateNext = S_DONE;
      default:     stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.loadA  = (state == S_IDLE)    && entryValid;
    stb.loadOp = (state == S_LOAD_A)  && opValid;
    stb.loadB  = (state == S_LOAD_OP) && entryValid;
    stb.exec   = (state == S_EXEC);
    stb.fix    = (state == S_FIXUP);
  end

  always_comb begin
    case (state)
      S_EXEC, S_SIGN_TEST, S_FIXUP, S_DONE: busy = 1'b1;
      default:                              busy = 1'b0;
    endcase
  end

  assign donePulse = (state == S_DONE);

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7: busy only drops right after the completion cycle
  a_r7_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(donePulse));

  // R2: equals while waiting for it starts execution
  a_r2_eq_starts_exec: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOAD_B && eqStrobe) |=> busy);

  // R8: no operand load strobe while busy
  a_r8_no_load_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.loadA || stb.loadB || stb.loadOp));
endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
  import calc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStb_t     stb,
  input  logic [W-2:0] entryMag,
  input  logic         entryNeg,
  input  logic         opSub,
  output logic         resMsb,
  output logic [W-1:0] resultMag,
  output logic         resultNeg,
  output logic         ovfFlag
);
  localparam int MSB = W - 1;

  logic [W-1:0] regA, regB, resultReg;
  logic         subReg;
  logic [W-1:0] entryWord, entryTrue, entryInv;
  logic [W-1:0] addX, addY, addSum;
  logic         addCin;

  // operand entry: true and ones'-complement views of the magnitude
  assign entryTrue = {1'b0, entryMag};
  assign entryInv  = ~entryTrue;
  assign entryWord = entryNeg ? (entryInv + {{(W-1){1'b0}}, 1'b1}) : entryTrue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      subReg <= 1'b0;
    end else begin
      if (stb.loadA)  regA   <= entryWord;
      if (stb.loadB)  regB   <= entryWord;
      if (stb.loadOp) subReg <= opSub;
    end
  end

  // one shared adder: execute pass or fix-up (negate) pass
  always_comb begin
    if (stb.fix) begin
      addX   = '0;
      addY   = ~resultReg;
      addCin = 1'b1;
    end else begin
      addX   = regA;
      addY   = subReg ? ~regB : regB;
      addCin = subReg;
    end
  end

  calc_adder #(.W(W)) u_adder (
    .x   (addX),
    .y   (addY),
    .cin (addCin),
    .sum (addSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      resultNeg <= 1'b0;
      ovfFlag   <= 1'b0;
    end else if (stb.exec) begin
      resultReg <= addSum;
      resultNeg <= 1'b0;
      ovfFlag   <= (addX[MSB] == addY[MSB]) && (addSum[MSB] != addX[MSB]);
    end else if (stb.fix) begin
      resultReg <= addSum;
      resultNeg <= 1'b1;
    end
  end

  assign resMsb    = resultReg[MSB];
  assign resultMag = resultReg;

  // R1: positive entry lands with a clear sign bit
  a_r1_pos_entry_sign: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadA && !entryNeg) |=> !regA[MSB]);

  // R5: fix-up pass raises the minus flag
  a_r5_fix_sets_neg: assert property (@(posedge clk) disable iff (!rstN)
    stb.fix |=> resultNeg);

  // R6: overflow status held between executions
  a_r6_ovf_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.exec |=> $stable(ovfFlag));

  // R3: result only moves on an execute or fix-up pass
  a_r3_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.exec || stb.fix) |=> $stable(resultReg));
endmodule

// File: rtl/addsub_calc_seq.sv
module addsub_calc_seq
  import calc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         entryValid,
  input  logic         entryNeg,
  input  logic [W-2:0] entryMag,
  input  logic         opValid,
  input  logic         opSub,
  input  logic         eqStrobe,
  output logic [W-1:0] resultMag,
  output logic         resultNeg,
  output logic         ovfFlag,
  output logic         busy,
  output logic         donePulse
);
  ctrlStb_t stb;
  logic     resMsb;

  calc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .entryValid (entryValid),
    .opValid    (opValid),
    .eqStrobe   (eqStrobe),
    .resMsb     (resMsb),
    .stb        (stb),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  calc_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .entryMag  (entryMag),
    .entryNeg  (entryNeg),
    .opSub     (opSub),
    .resMsb    (resMsb),
    .resultMag (resultMag),
    .resultNeg (resultNeg),
    .ovfFlag   (ovfFlag)
  );
endmodule

// File: tb/sim_addsub_calc_seq.sv
module sim_addsub_calc_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       entryValid = 1'b0, entryNeg = 1'b0, opValid = 1'b0, opSub = 1'b0, eqStrobe = 1'b0;
  logic [6:0] entryMag = '0;
  logic [7:0] resultMag;
  logic       resultNeg, ovfFlag, busy, donePulse;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  addsub_calc_seq #(.W(8)) u0 (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryNeg(entryNeg),
    .entryMag(entryMag), .opValid(opValid), .opSub(opSub), .eqStrobe(eqStrobe),
    .resultMag(resultMag), .resultNeg(resultNeg), .ovfFlag(ovfFlag),
    .busy(busy), .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input int magA, input bit negA, input bit sub,
                       input int magB, input bit negB,
                       input bit strayWait, input bit strayBusy);
    int sa, sb, r, r8, expMag, cyc;
    bit expNeg, expOvf;
    sa = negA ? -magA : magA;
    sb = negB ? -magB : magB;
    r = sub ? sa - sb : sa + sb;
    expOvf = (r > 127) || (r < -128);
    r8 = r & 255;
    expNeg = r8[7];
    expMag = expNeg ? ((256 - r8) & 255) : r8;

    @(negedge clk); entryValid = 1; entryMag = magA[6:0]; entryNeg = negA;
    @(negedge clk); entryValid = 0; opValid = 1; opSub = sub;
    @(negedge clk); opValid = 0; entryValid = 1; entryMag = magB[6:0]; entryNeg = negB;
    @(negedge clk); entryValid = 0;
    if (strayWait) begin
      // R2: stray operand and flipped operator while waiting for equals
      entryValid = 1; entryMag = 7'd77; entryNeg = ~negB; opValid = 1; opSub = ~sub;
      @(negedge clk); entryValid = 0; opValid = 0;
    end
    eqStrobe = 1;
    @(negedge clk); eqStrobe = 0;
    cyc = 0;
    while (!donePulse && cyc < 8) begin
      @(negedge clk);
      cyc++;
      if (strayBusy && cyc == 1) begin
        chk(busy == 1'b1, "R7 busy during run", busy, 1);
        entryValid = 1; entryMag = 7'd33; entryNeg = 1; opValid = 1; opSub = ~sub; // R8
      end else begin
        entryValid = 0; opValid = 0;
      end
    end
    entryValid = 0; opValid = 0;
    chk(cyc == (expNeg ? 3 : 2), "R7 done latency", cyc, expNeg ? 3 : 2);
    chk(resultMag == expMag[7:0], sub ? "R4 R5 magnitude" : "R3 R5 magnitude", resultMag, expMag);
    chk(resultNeg == expNeg, "R5 sign flag", resultNeg, expNeg);
    chk(ovfFlag == expOvf, "R6 overflow", ovfFlag, expOvf);
    chk(busy == 1'b1, "R7 busy at done", busy, 1);
    @(negedge clk);
    chk(donePulse == 1'b0, "R7 single pulse", donePulse, 0);
    chk(busy == 1'b0, "R7 busy released", busy, 0);
    chk(ovfFlag == expOvf && resultMag == expMag[7:0], "R6 R8 result held", resultMag, expMag);
  endtask

  initial begin
    #15;
    chk(resultMag == 0, "R9 reset magnitude", resultMag, 0);
    chk(resultNeg == 0, "R9 reset sign", resultNeg, 0);
    chk(ovfFlag == 0, "R9 reset overflow", ovfFlag, 0);
    chk(busy == 0, "R9 reset busy", busy, 0);
    chk(donePulse == 0, "R9 reset done", donePulse, 0);
    #20 rstN = 1'b1;
    // R5: the two worked examples
    runOp(9, 0, 1, 4, 0, 0, 0);
    runOp(4, 0, 1, 9, 0, 0, 0);
    // R1 R6: extremes
    runOp(100, 0, 0, 100, 0, 0, 0);
    runOp(127, 1, 1, 127, 0, 0, 0);
    runOp(0, 1, 0, 0, 1, 1, 1);
    // R3 R4: sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int k = 0; k < 8; k++) begin
          int va, vb;
          va = (i == 15) ? 127 : i * 9;
          vb = (j == 15) ? 127 : j * 9;
          runOp(va, k[0], k[2], vb, k[1], ((i + j + k) % 5) == 0, ((i + k) % 3) == 0);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule